// File: doc/BRIEF.md
# T1 Receive Alarm Detector

This block watches a recovered DS1 receive stream and keeps three alarm flags as plain levels for a status register: a bit-2 yellow alarm, a facility-data-link (FDL) yellow alarm, and a blue alarm (alarm indication signal). The framer upstream supplies one received bit per valid cycle. It marks each bit with strobes that say whether it is the framing bit, a channel's bit 2, or an FDL bit. It also reports whether it currently holds frame alignment. A mode input selects between superframe (D4) operation and extended superframe (ESF) operation.

A frame is one framing bit followed by 24 channels of 8 payload bits. The block gathers per-frame facts as the payload goes by: whether any payload bit was 0, and whether any channel's bit 2 was 1. It also counts the payload bits and the bit-2 strobes. When the next framing bit arrives, the frame is closed and judged. The bit-2 yellow flag and the blue flag change only on those framing-bit edges. The FDL yellow flag is separate. It is fed by a 16-deep history of FDL bits and is judged every time an FDL bit arrives.

Top module: `t1_rx_alarm`

## Requirements
- R1: An asynchronous active-low reset forces all three flags low and discards all frame, run and FDL history.
- R2: A framing bit (`rx_vld` and `fbit_stb` both high) closes the frame in progress. The bit-2 yellow and blue flags change only on such an edge and can be read in the following cycle. Only a complete frame moves them: one with exactly 192 payload bits, 24 of which carried `bit2_stb`. Short or long frames leave both flags as they were.
- R3: `yel_alarm` is set when a complete frame has bit 2 received as 0 in every channel.
- R4: `yel_alarm` is cleared when a complete frame has bit 2 received as 1 in any channel.
- R5: `blue_alarm` is set at the close of a complete all-ones frame that is at least the second consecutive such frame, provided `in_frame` is low at that closing edge.
- R6: While `in_frame` is high at the closing edge, `blue_alarm` is not set, however many all-ones frames have arrived.
- R7: `blue_alarm` is cleared at the close of any complete frame holding at least one payload 0. Such a frame also restarts the all-ones run.
- R8: With `esf_mode` high, each FDL bit (`rx_vld` and `fdl_stb`) enters a 16-bit history. `esf_yel_alarm` is set on the FDL bit that makes the last 16 bits read eight 1s followed by eight 0s, oldest first.
- R9: `esf_yel_alarm` is cleared on the 16th consecutive FDL bit after which the history does not hold that pattern.
- R10: With `esf_mode` low, `esf_yel_alarm` is held low and the FDL history and miss count are emptied. Pattern bits sent before ESF is entered therefore never complete a match.
- R11: Cycles with `rx_vld` low are ignored by every part of the block, whatever `rx_bit` and the strobes carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| rx_vld | input | 1 | A received bit is present this cycle |
| rx_bit | input | 1 | Received bit value |
| fbit_stb | input | 1 | The present bit is the framing bit |
| bit2_stb | input | 1 | The present bit is bit 2 of a channel |
| fdl_stb | input | 1 | The present bit is an FDL bit |
| in_frame | input | 1 | Framer holds frame alignment (low means out of frame) |
| esf_mode | input | 1 | 1 selects ESF operation, 0 selects D4 |
| yel_alarm | output | 1 | Bit-2 yellow alarm |
| esf_yel_alarm | output | 1 | FDL-pattern yellow alarm |
| blue_alarm | output | 1 | All-ones (alarm indication signal) alarm |

## Verification
The bench places a single payload 0 at a spread of positions across a blue-alarmed frame. A design that tested only some channels, or looked at the framing bit, would leave the alarm set. The bench also moves the lone bit-2 one across all 24 channels, which exposes a yellow detector that misses any channel. It sends short and overlong frames and cycles with `rx_vld` low carrying zeros; a design that judged every closed frame, or accepted unqualified bits, would drop the flags. The bench runs the FDL history through the clean pattern, every single-bit corruption of it, and a long pseudo-random stream against an arithmetic model. This catches an off-by-one in the 16-bit set and clear windows. It also confirms that D4 mode empties the history, so that a design keeping stale bits would raise a false ESF alarm.

// File: rtl/t1ra_pkg.sv
package t1ra_pkg;

  // Digest of one closed frame, handed from the accumulator to the judges.
  typedef struct packed {
    logic complete;     // exact payload and bit-2 strobe counts seen
    logic any_zero;     // at least one payload bit was 0
    logic any_b2_one;   // at least one channel carried bit 2 = 1
  } frame_sum_t;

endpackage

// File: rtl/t1ra_frame_acc.sv
module t1ra_frame_acc
  import t1ra_pkg::*;
#(
  parameter int NCHAN  = 24,
  parameter int CHBITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_vld,
  input  logic       rx_bit,
  input  logic       fbit_stb,
  input  logic       bit2_stb,
  output logic       close_o,
  output frame_sum_t sum_o
);

  localparam int NBITS = NCHAN * CHBITS;
  localparam int CW    = $clog2(NBITS + 2);
  localparam int BW    = $clog2(NCHAN + 2);
  localparam logic [CW-1:0] BCNT_MAX  = CW'(NBITS + 1);
  localparam logic [BW-1:0] B2CNT_MAX = BW'(NCHAN + 1);

  logic          started_q, started_d;
  logic [CW-1:0] bcnt_q, bcnt_d;
  logic [BW-1:0] b2cnt_q, b2cnt_d;
  logic          zero_q, zero_d;
  logic          b2one_q, b2one_d;
  logic          fbit_hit, pay_hit;

  assign fbit_hit = rx_vld & fbit_stb;
  assign pay_hit  = rx_vld & ~fbit_stb;

  always_comb begin
    started_d = started_q;
    bcnt_d    = bcnt_q;
    b2cnt_d   = b2cnt_q;
    zero_d    = zero_q;
    b2one_d   = b2one_q;
    if (fbit_hit) begin
      started_d = 1'b1;
      bcnt_d    = '0;
      b2cnt_d   = '0;
      zero_d    = 1'b0;
      b2one_d   = 1'b0;
    end else if (pay_hit) begin
      if (bcnt_q != BCNT_MAX) bcnt_d = bcnt_q + 1'b1;
      if (!rx_bit) zero_d = 1'b1;
      if (bit2_stb) begin
        if (b2cnt_q != B2CNT_MAX) b2cnt_d = b2cnt_q + 1'b1;
        if (rx_bit) b2one_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      bcnt_q    <= '0;
      b2cnt_q   <= '0;
      zero_q    <= 1'b0;
      b2one_q   <= 1'b0;
    end else begin
      started_q <= started_d;
      bcnt_q    <= bcnt_d;
      b2cnt_q   <= b2cnt_d;
      zero_q    <= zero_d;
      b2one_q   <= b2one_d;
    end
  end

  // The first framing bit after reset only opens a frame; later ones close one.
  assign close_o = fbit_hit & started_q;

  always_comb begin
    sum_o.complete   = (bcnt_q == CW'(NBITS)) && (b2cnt_q == BW'(NCHAN));
    sum_o.any_zero   = zero_q;
    sum_o.any_b2_one = b2one_q;
  end

endmodule

// File: rtl/t1ra_d4_yel.sv
module t1ra_d4_yel
  import t1ra_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       close_i,
  input  frame_sum_t sum_i,
  output logic       yel_o
);

  logic yel_q, yel_d;

  always_comb begin
    yel_d = yel_q;
    if (close_i && sum_i.complete) yel_d = ~sum_i.any_b2_one;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) yel_q <= 1'b0;
    else        yel_q <= yel_d;
  end

  assign yel_o = yel_q;

endmodule

// File: rtl/t1ra_blue.sv
module t1ra_blue
  import t1ra_pkg::*;
#(
  parameter int RUN_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       close_i,
  input  frame_sum_t sum_i,
  input  logic       in_frame,
  output logic       blue_o
);

  localparam int OW = $clog2(RUN_FRAMES + 1);
  localparam logic [OW-1:0] RUN_MAX = OW'(RUN_FRAMES);

  logic [OW-1:0] run_q, run_d;
  logic          blue_q, blue_d;

  always_comb begin
    run_d  = run_q;
    blue_d = blue_q;
    if (close_i && sum_i.complete) begin
      if (sum_i.any_zero) begin
        run_d  = '0;
        blue_d = 1'b0;
      end else begin
        if (run_q != RUN_MAX) run_d = run_q + 1'b1;
        if ((run_d == RUN_MAX) && !in_frame) blue_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      blue_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      blue_q <= blue_d;
    end
  end

  assign blue_o = blue_q;

endmodule

// File: rtl/t1ra_esf_yel.sv
module t1ra_esf_yel #(
  parameter int HIST = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic esf_mode,
  input  logic rx_vld,
  input  logic rx_bit,
  input  logic fdl_stb,
  output logic esf_yel_o
);

  localparam int HALF = HIST / 2;
  localparam int MW   = $clog2(HIST);
  localparam logic [MW-1:0] MISS_LAST = MW'(HIST - 1);

  // Oldest bit at the MSB: upper half ones, lower (newest) half zeros.
  logic [HIST-1:0] pat;
  for (genvar gi = 0; gi < HIST; gi++) begin : g_pat
    assign pat[gi] = (gi >= HALF);
  end

  logic [HIST-1:0] hist_q, hist_d;
  logic [MW-1:0]   miss_q, miss_d;
  logic            flag_q, flag_d;
  logic            fdl_hit;

  assign fdl_hit = rx_vld & fdl_stb;

  always_comb begin
    hist_d = hist_q;
    miss_d = miss_q;
    flag_d = flag_q;
    if (!esf_mode) begin
      hist_d = '0;
      miss_d = '0;
      flag_d = 1'b0;
    end else if (fdl_hit) begin
      hist_d = {hist_q[HIST-2:0], rx_bit};
      if (hist_d == pat) begin
        flag_d = 1'b1;
        miss_d = '0;
      end else if (miss_q == MISS_LAST) begin
        flag_d = 1'b0;
        miss_d = '0;
      end else begin
        miss_d = miss_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      miss_q <= '0;
      flag_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      miss_q <= miss_d;
      flag_q <= flag_d;
    end
  end

  assign esf_yel_o = flag_q;

endmodule

// File: rtl/t1_rx_alarm.sv
module t1_rx_alarm
  import t1ra_pkg::*;
#(
  parameter int NCHAN      = 24,
  parameter int CHBITS     = 8,
  parameter int RUN_FRAMES = 2,
  parameter int FDL_HIST   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_vld,
  input  logic rx_bit,
  input  logic fbit_stb,
  input  logic bit2_stb,
  input  logic fdl_stb,
  input  logic in_frame,
  input  logic esf_mode,
  output logic yel_alarm,
  output logic esf_yel_alarm,
  output logic blue_alarm
);

  logic       frm_close;
  frame_sum_t frm_sum;

  t1ra_frame_acc #(
    .NCHAN  (NCHAN),
    .CHBITS (CHBITS)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_vld   (rx_vld),
    .rx_bit   (rx_bit),
    .fbit_stb (fbit_stb),
    .bit2_stb (bit2_stb),
    .close_o  (frm_close),
    .sum_o    (frm_sum)
  );

  t1ra_d4_yel u_yel (
    .clk     (clk),
    .rst_n   (rst_n),
    .close_i (frm_close),
    .sum_i   (frm_sum),
    .yel_o   (yel_alarm)
  );

  t1ra_blue #(
    .RUN_FRAMES (RUN_FRAMES)
  ) u_blue (
    .clk      (clk),
    .rst_n    (rst_n),
    .close_i  (frm_close),
    .sum_i    (frm_sum),
    .in_frame (in_frame),
    .blue_o   (blue_alarm)
  );

  t1ra_esf_yel #(
    .HIST (FDL_HIST)
  ) u_esf (
    .clk       (clk),
    .rst_n     (rst_n),
    .esf_mode  (esf_mode),
    .rx_vld    (rx_vld),
    .rx_bit    (rx_bit),
    .fdl_stb   (fdl_stb),
    .esf_yel_o (esf_yel_alarm)
  );

endmodule

// File: rtl/t1ra_chk.sv
module t1ra_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_vld,
  input logic fbit_stb,
  input logic fdl_stb,
  input logic in_frame,
  input logic esf_mode,
  input logic yel_alarm,
  input logic esf_yel_alarm,
  input logic blue_alarm
);

  // R2 / R11: frame flags move only on a valid framing bit
  p_frame_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_vld && fbit_stb) |=> ($stable(yel_alarm) && $stable(blue_alarm)));

  // R5: blue rises only when the framer was out of frame at the closing edge
  p_blue_oof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blue_alarm) |-> $past(!in_frame));

  // R6: in-frame never lets blue rise
  p_blue_framed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !blue_alarm) |=> !blue_alarm);

  // R10: D4 mode holds the FDL alarm low
  p_d4_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !esf_mode |=> !esf_yel_alarm);

  // R11: FDL alarm moves only on a valid FDL bit
  p_fdl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (esf_mode && !(rx_vld && fdl_stb)) |=> $stable(esf_yel_alarm));

  // R3: yellow rises only on a closing framing bit
  p_yel_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(yel_alarm) |-> $past(rx_vld && fbit_stb));

endmodule

bind t1_rx_alarm t1ra_chk u_t1ra_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_vld        (rx_vld),
  .fbit_stb      (fbit_stb),
  .fdl_stb       (fdl_stb),
  .in_frame      (in_frame),
  .esf_mode      (esf_mode),
  .yel_alarm     (yel_alarm),
  .esf_yel_alarm (esf_yel_alarm),
  .blue_alarm    (blue_alarm)
);

// File: tb/test_t1_rx_alarm.sv
`timescale 1ns/1ps
module test_t1_rx_alarm;

  logic clk = 1'b0;
  logic rst_n, rx_vld, rx_bit, fbit_stb, bit2_stb, fdl_stb, in_frame, esf_mode;
  logic yel_alarm, esf_yel_alarm, blue_alarm;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // FDL reference model state
  logic [15:0] m_hist;
  int          m_miss;
  logic        m_flag;

  localparam int PAY = 192;
  localparam int K_ONES = 0, K_ZERO_AT = 1, K_B2_ZERO = 2, K_B2_ONE_AT = 3;

  always #5 clk = ~clk;

  t1_rx_alarm i_t1_rx_alarm (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_bit(rx_bit),
    .fbit_stb(fbit_stb), .bit2_stb(bit2_stb), .fdl_stb(fdl_stb),
    .in_frame(in_frame), .esf_mode(esf_mode),
    .yel_alarm(yel_alarm), .esf_yel_alarm(esf_yel_alarm), .blue_alarm(blue_alarm)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // One cycle of input; outputs reflecting it are readable on return.
  task automatic push(input logic v, input logic fb, input logic b2,
                      input logic fd, input logic b);
    @(negedge clk);
    rx_vld = v; fbit_stb = fb; bit2_stb = b2; fdl_stb = fd; rx_bit = b;
    @(posedge clk);
    #1;
    rx_vld = 1'b0; fbit_stb = 1'b0; bit2_stb = 1'b0; fdl_stb = 1'b0; rx_bit = 1'b0;
  endtask

  function automatic logic pbit(input int kind, input int arg, input int p);
    case (kind)
      K_ZERO_AT:   return logic'(p != arg);
      K_B2_ZERO:   return logic'((p % 8) != 1);
      K_B2_ONE_AT: return ((p % 8) == 1) ? logic'((p / 8) == arg) : 1'b1;
      default:     return 1'b1;
    endcase
  endfunction

  // Payload of nbits bits; bit 2 of each channel is index 1 within the channel.
  task automatic payload(input int kind, input int arg, input int nbits, input bit gaps);
    for (int p = 0; p < nbits; p++) begin
      if (gaps && (p % 5 == 0)) push(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
      push(1'b1, 1'b0, logic'((p % 8) == 1), 1'b0, pbit(kind, arg, p));
    end
  endtask

  task automatic close_frame();
    push(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic frame(input int kind, input int arg);
    payload(kind, arg, PAY, 1'b0);
    close_frame();
  endtask

  task automatic model_reset();
    m_hist = '0; m_miss = 0; m_flag = 1'b0;
  endtask

  // FDL bit carried on the framing position (closes only empty/short frames).
  task automatic fdl(input logic b, input string req);
    push(1'b1, 1'b1, 1'b0, 1'b1, b);
    if (esf_mode) begin
      m_hist = {m_hist[14:0], b};
      if (m_hist == 16'hFF00) begin m_flag = 1'b1; m_miss = 0; end
      else if (m_miss == 15) begin m_flag = 1'b0; m_miss = 0; end
      else m_miss++;
    end else model_reset();
    chk(req, esf_yel_alarm, m_flag);
  endtask

  task automatic fdl_pattern(input int flip);
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = logic'(i < 8);
      if (i == flip) b = ~b;
      fdl(b, (i == 15 && flip < 0) ? "R8" : "R9");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; rx_vld = 0; rx_bit = 0; fbit_stb = 0; bit2_stb = 0; fdl_stb = 0;
    in_frame = 1'b1; esf_mode = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 yel", yel_alarm, 1'b0);
    chk("R1 esf", esf_yel_alarm, 1'b0);
    chk("R1 blue", blue_alarm, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R6: framed all-ones never raises blue
    push(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int f = 0; f < 3; f++) begin
      frame(K_ONES, 0);
      chk("R6", blue_alarm, 1'b0);
    end
    // R5: out of frame with run already long enough
    in_frame = 1'b0;
    frame(K_ONES, 0);
    chk("R5 saturated run", blue_alarm, 1'b1);

    // R7 sweep of zero position, R5 two-frame rebuild
    for (int p = 0; p < PAY; p += 3) begin
      frame(K_ZERO_AT, p);
      chk("R7 zero clears", blue_alarm, 1'b0);
      frame(K_ONES, 0);
      chk("R5 one frame", blue_alarm, 1'b0);
      frame(K_ONES, 0);
      chk("R5 two frames", blue_alarm, 1'b1);
    end

    // R2: short and overlong frames with zeros leave blue
    payload(K_ZERO_AT, 3, 100, 1'b0); close_frame();
    chk("R2 short", blue_alarm, 1'b1);
    payload(K_ONES, 0, PAY, 1'b0); push(1'b1, 1'b0, 1'b0, 1'b0, 1'b0); close_frame();
    chk("R2 long", blue_alarm, 1'b1);

    // R3 / R4 sweep over channels
    frame(K_B2_ZERO, 0);
    chk("R3 set", yel_alarm, 1'b1);
    chk("R7 b2 zeros", blue_alarm, 1'b0);
    for (int k = 0; k < 24; k++) begin
      frame(K_B2_ONE_AT, k);
      chk("R4 clear", yel_alarm, 1'b0);
      frame(K_B2_ZERO, 0);
      chk("R3 set", yel_alarm, 1'b1);
    end
    payload(K_ONES, 0, 40, 1'b0); close_frame();
    chk("R2 short keeps yel", yel_alarm, 1'b1);

    // R11: gap cycles carrying zeros and strobes are ignored
    payload(K_ONES, 0, PAY, 1'b1); close_frame();
    chk("R11 gap frame 1", blue_alarm, 1'b0);
    chk("R11 yel clears", yel_alarm, 1'b0);
    payload(K_ONES, 0, PAY, 1'b1); close_frame();
    chk("R11 gap frame 2", blue_alarm, 1'b1);

    // R8 / R9: FDL history against model
    esf_mode = 1'b1;
    model_reset();
    fdl_pattern(-1);
    chk("R8 clean pattern", esf_yel_alarm, 1'b1);
    for (int i = 0; i < 16; i++) fdl(1'b1, "R9");
    chk("R9 cleared", esf_yel_alarm, 1'b0);
    for (int k = 0; k < 16; k++) fdl_pattern(k);
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      if (i % 97 == 0) fdl_pattern(-1);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fdl(lfsr[0], "R9");
    end

    // R10: D4 mode drops flag and history
    fdl_pattern(-1);
    esf_mode = 1'b0;
    push(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 drop", esf_yel_alarm, 1'b0);
    model_reset();
    for (int i = 0; i < 16; i++) fdl(logic'(i < 8), "R10");
    for (int i = 0; i < 8; i++) fdl(1'b1, "R10");
    esf_mode = 1'b1;
    for (int i = 0; i < 8; i++) fdl(1'b0, "R10 stale");

    // R1: reset mid-run
    fdl_pattern(-1);
    frame(K_B2_ZERO, 0);
    @(negedge clk); rst_n = 1'b0;
    #2;
    chk("R1 async yel", yel_alarm, 1'b0);
    chk("R1 async esf", esf_yel_alarm, 1'b0);
    chk("R1 async blue", blue_alarm, 1'b0);
    summary();
  end

endmodule